// File: doc/BRIEF.md
# Dual-Port Shared Work RAM Bank Allocator

This block owns a shared work RAM and hands it out to two CPU ports, A and B, under the control of a small mode register. The array is built as two equal halves. The mode decides whether port A gets both halves, port B gets both halves, or each port gets one half, in either arrangement. The address bits above the owned range are ignored, so an owned range repeats (mirrors) through the whole window. Port A reads zero from the shared window when it owns nothing, and its writes there are discarded. Port B has a private RAM of twice the shared size. When B owns no shared half, its shared-window accesses go to that private RAM instead. B can also reach the private RAM directly at any time.

Both ports share one access shape. Each has an enable, a register-select flag, an address, four byte-lane write enables and 32-bit write data. An access with all lane enables low is a read. Read data appears one cycle after the request, as all memories are synchronous. The shared array size is set by `SH_AW`, the number of byte-address bits. The default of 10 gives a 1 KB array, which keeps elaboration small. Setting `SH_AW` to 15 gives a 32 KB shared array and a 64 KB private RAM.

Top module: `shram_alloc`

## Requirements
- R1: After reset, the mode register is 0x00 and both read-data outputs are zero.
- R2: In mode 0, port A owns the whole shared array at byte offset `addr & (2^SH_AW-1)`. Port B shared-window accesses go to its private RAM.
- R3: In mode 1, port A sees the upper half at offset `addr & (2^(SH_AW-1)-1)` and port B sees the lower half at the same offset. Neither half is ever accessed by both ports in one cycle.
- R4: In mode 2, port A sees the lower half and port B sees the upper half, both with the half-size mask. Contents are kept across mode changes, so switching between modes 1 and 2 swaps the two views.
- R5: In mode 3, port B owns the whole shared array with the full mask. Port A shared reads return zero and port A shared writes change nothing.
- R6: Private RAM accesses use offset `addr & (2^(SH_AW+1)-1)`. They happen when `b_priv` is set in any mode, and for port B shared-window accesses in mode 0.
- R7: When `a_reg` is set, a write with lane 0 enabled loads `a_wdata[7:0]` into the 8-bit register. The low 2 bits of that register are the mode. Writes from port B with `b_reg` set have no effect. A read with the register flag set returns the register in bits 7:0 and zero in bits 31:8. The value returned is the one held after the request cycle.
- R8: A mode write takes effect for accesses in the following cycle. An access issued in the same cycle as the write uses the old mapping.
- R9: Only the byte lanes whose write enable is set are written. Address bits 1:0 are ignored, and lane n is bits 8n+7:8n of the word.
- R10: Read data is valid exactly one cycle after a read request. The cycle after an idle cycle or a write, the read-data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A access request |
| a_reg | input | 1 | Port A targets the mode register |
| a_addr | input | ADDR_W | Port A byte address |
| a_we | input | 4 | Port A byte-lane write enables |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data, one cycle after the request |
| b_en | input | 1 | Port B access request |
| b_reg | input | 1 | Port B targets the mode register (read only) |
| b_priv | input | 1 | Port B targets its private RAM directly |
| b_addr | input | ADDR_W | Port B byte address |
| b_we | input | 4 | Port B byte-lane write enables |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data, one cycle after the request |

## Verification
The assertions check several properties on every cycle:
- neither half-bank is ever claimed by both ports;
- the register changes only after a port A register write, which also means B cannot alter it;
- port A reads in mode 3 return zero;
- idle cycles and writes leave a zero readback.

Some behaviours can only be shown by the bench's scenarios against its byte-level reference model. These are the mirroring of each bank through the full address range, the swap of halves between modes 1 and 2, the fallback of B to private RAM, lane-selective writes, and the old-mapping use on the cycle of a mode write.

// File: rtl/shram_pkg.sv
package shram_pkg;

    localparam int DW = 32;
    localparam int NB = DW / 8;

    // Destination of one port access, and the readback source one cycle later
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_LO   = 3'd1,
        SRC_HI   = 3'd2,
        SRC_PRIV = 3'd3,
        SRC_REG  = 3'd4
    } src_e;

    typedef struct packed {
        logic [7:0] ctrl;
        src_e       a_src;
        src_e       b_src;
    } state_t;

endpackage

// File: rtl/shram_mem.sv
module shram_mem
    import shram_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we[g]) begin
                    mem[addr] <= wdata[8*g +: 8];
                end
                rd_q <= mem[addr];
            end
        end

        assign rdata[8*g +: 8] = rd_q;
    end

endmodule

// File: rtl/shram_route.sv
module shram_route
    import shram_pkg::*;
#(
    parameter bit IS_B   = 1'b0,
    parameter int SH_AW  = 10,
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        mode,
    input  logic              en,
    input  logic              is_reg,
    input  logic              priv,
    input  logic [ADDR_W-1:0] addr,
    output src_e              dst
);

    logic upper;
    assign upper = addr[SH_AW-1];

    always_comb begin
        dst = SRC_NONE;
        if (!en) begin
            dst = SRC_NONE;
        end else if (is_reg) begin
            dst = SRC_REG;
        end else if (IS_B && priv) begin
            dst = SRC_PRIV;
        end else begin
            unique case (mode)
                2'd0: dst = IS_B ? SRC_PRIV : (upper ? SRC_HI : SRC_LO);
                2'd1: dst = IS_B ? SRC_LO : SRC_HI;
                2'd2: dst = IS_B ? SRC_HI : SRC_LO;
                2'd3: dst = IS_B ? (upper ? SRC_HI : SRC_LO) : SRC_NONE;
                default: dst = SRC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/shram_alloc.sv
module shram_alloc
    import shram_pkg::*;
#(
    parameter int SH_AW  = 10,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_reg,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [3:0]        a_we,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    input  logic              b_en,
    input  logic              b_reg,
    input  logic              b_priv,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [3:0]        b_we,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata
);

    localparam int PR_AW = SH_AW + 1;   // private RAM is twice the shared size
    localparam int HW    = SH_AW - 3;   // word index width of one half-bank
    localparam int PW    = PR_AW - 2;   // word index width of the private RAM

    state_t st_d, st_q;
    src_e   a_dst, b_dst;

    logic [1:0]    a_bank_hit, b_bank_hit;
    logic [DW-1:0] bank_rd [2];
    logic [DW-1:0] priv_rd;

    shram_route #(.IS_B(1'b0), .SH_AW(SH_AW), .ADDR_W(ADDR_W)) u_route_a (
        .mode   (st_q.ctrl[1:0]),
        .en     (a_en),
        .is_reg (a_reg),
        .priv   (1'b0),
        .addr   (a_addr),
        .dst    (a_dst)
    );

    shram_route #(.IS_B(1'b1), .SH_AW(SH_AW), .ADDR_W(ADDR_W)) u_route_b (
        .mode   (st_q.ctrl[1:0]),
        .en     (b_en),
        .is_reg (b_reg),
        .priv   (b_priv),
        .addr   (b_addr),
        .dst    (b_dst)
    );

    // Two half-banks, each driven by whichever port the mode assigns to it
    for (genvar k = 0; k < 2; k++) begin : g_bank
        localparam src_e MINE = (k == 1) ? SRC_HI : SRC_LO;

        logic          en_k;
        logic [HW-1:0] addr_k;
        logic [NB-1:0] we_k;
        logic [DW-1:0] wd_k;

        assign a_bank_hit[k] = (a_dst == MINE);
        assign b_bank_hit[k] = (b_dst == MINE);
        assign en_k   = a_bank_hit[k] | b_bank_hit[k];
        assign addr_k = a_bank_hit[k] ? a_addr[SH_AW-2:2] : b_addr[SH_AW-2:2];
        assign we_k   = a_bank_hit[k] ? a_we : (b_bank_hit[k] ? b_we : '0);
        assign wd_k   = a_bank_hit[k] ? a_wdata : b_wdata;

        shram_mem #(.AW(HW)) u_half (
            .clk   (clk),
            .en    (en_k),
            .addr  (addr_k),
            .we    (we_k),
            .wdata (wd_k),
            .rdata (bank_rd[k])
        );
    end

    logic p_en;
    assign p_en = (b_dst == SRC_PRIV);

    shram_mem #(.AW(PW)) u_priv (
        .clk   (clk),
        .en    (p_en),
        .addr  (b_addr[PR_AW-1:2]),
        .we    (p_en ? b_we : 4'b0000),
        .wdata (b_wdata),
        .rdata (priv_rd)
    );

    // Next-state: register write from port A lane 0, readback source per port
    always_comb begin
        st_d = st_q;
        if (a_dst == SRC_REG && a_we[0]) begin
            st_d.ctrl = a_wdata[7:0];
        end
        st_d.a_src = (a_we == 4'b0000) ? a_dst : SRC_NONE;
        st_d.b_src = (b_we == 4'b0000) ? b_dst : SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= 8'h00;
            st_q.a_src <= SRC_NONE;
            st_q.b_src <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.a_src)
            SRC_LO:  a_rdata = bank_rd[0];
            SRC_HI:  a_rdata = bank_rd[1];
            SRC_REG: a_rdata = {24'h0, st_q.ctrl};
            default: a_rdata = '0;
        endcase
        unique case (st_q.b_src)
            SRC_LO:   b_rdata = bank_rd[0];
            SRC_HI:   b_rdata = bank_rd[1];
            SRC_PRIV: b_rdata = priv_rd;
            SRC_REG:  b_rdata = {24'h0, st_q.ctrl};
            default:  b_rdata = '0;
        endcase
    end

endmodule

// File: rtl/shram_alloc_chk.sv
module shram_alloc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        a_en,
    input logic        a_reg,
    input logic [3:0]  a_we,
    input logic [31:0] a_wdata,
    input logic [31:0] a_rdata,
    input logic [7:0]  ctrl,
    input logic [1:0]  a_bank_hit,
    input logic [1:0]  b_bank_hit
);

    logic a_ctrl_wr;
    assign a_ctrl_wr = a_en && a_reg && a_we[0];

    // R3: a half-bank is never claimed by both ports in one cycle
    a_r3_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bank_hit & b_bank_hit) == 2'b00);

    // R5: port A shared reads in mode 3 return zero
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_reg && a_we == 4'b0000 && ctrl[1:0] == 2'd3) |=> (a_rdata == 32'h0));

    // R7: without a port A register write, the register holds its value
    a_r7_hold_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !a_ctrl_wr |=> $stable(ctrl));

    // R8: a port A register write is visible in the next cycle
    a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        a_ctrl_wr |=> (ctrl == $past(a_wdata[7:0])));

    // R10: idle or write cycles leave a zero readback
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en || a_we != 4'b0000) |=> (a_rdata == 32'h0));

endmodule

bind shram_alloc shram_alloc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_en       (a_en),
    .a_reg      (a_reg),
    .a_we       (a_we),
    .a_wdata    (a_wdata),
    .a_rdata    (a_rdata),
    .ctrl       (st_q.ctrl),
    .a_bank_hit (a_bank_hit),
    .b_bank_hit (b_bank_hit)
);

// File: tb/shram_alloc_test.sv
module shram_alloc_test;

    localparam int SH_AW  = 10;
    localparam int ADDR_W = 16;
    localparam int S = 1 << SH_AW;
    localparam int H = S / 2;
    localparam int P = 2 * S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_reg = 0, b_en = 0, b_reg = 0, b_priv = 0;
    logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
    logic [3:0]  a_we = '0, b_we = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;

    always #5 clk = ~clk;

    shram_alloc #(.SH_AW(SH_AW), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_reg(a_reg), .a_addr(a_addr), .a_we(a_we),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_reg(b_reg), .b_priv(b_priv), .b_addr(b_addr),
        .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    // Reference model state
    logic [7:0] sh [S];
    logic [7:0] pv [P];
    logic [7:0] m_ctrl = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic int a_phys(input int m, input int ad);
        case (m)
            0: return (ad & (S-1)) & ~3;
            1: return (H + (ad & (H-1))) & ~3;
            2: return (ad & (H-1)) & ~3;
            default: return -1;
        endcase
    endfunction

    function automatic int b_phys(input int m, input int ad);
        case (m)
            1: return (ad & (H-1)) & ~3;
            2: return (H + (ad & (H-1))) & ~3;
            3: return (ad & (S-1)) & ~3;
            default: return -1;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One clock: drive at the falling edge, predict, compare at the next falling edge
    task automatic cyc(input logic ae, input logic ar, input int aa, input logic [3:0] aw,
                       input logic [31:0] ad, input logic be, input logic br, input logic bp,
                       input int ba, input logic [3:0] bw, input logic [31:0] bd,
                       input string tg);
        int m, pa, pb, pp;
        logic [7:0] nctrl;
        logic [31:0] ea, eb;
        string ta, tb;
        m = int'(m_ctrl[1:0]);
        a_en = ae; a_reg = ar; a_addr = ADDR_W'(aa); a_we = aw; a_wdata = ad;
        b_en = be; b_reg = br; b_priv = bp; b_addr = ADDR_W'(ba); b_we = bw; b_wdata = bd;
        nctrl = m_ctrl;
        if (ae && ar && aw[0]) nctrl = ad[7:0];
        pa = a_phys(m, aa & 16'hFFFF);
        pb = b_phys(m, ba & 16'hFFFF);
        pp = (ba & (P-1)) & ~3;
        ta = ar ? "R7" : (aw != 0 ? "R9" : mode_tag(m));
        tb = br ? "R7" : (bw != 0 ? "R9" : ((bp || m == 0) ? "R6" : mode_tag(m)));
        if (tg != "") begin ta = tg; tb = tg; end
        ea = 32'h0;
        if (ae && aw == 0) begin
            if (ar) ea = {24'h0, nctrl};
            else if (pa >= 0) ea = {sh[pa+3], sh[pa+2], sh[pa+1], sh[pa]};
        end
        eb = 32'h0;
        if (be && bw == 0) begin
            if (br) eb = {24'h0, nctrl};
            else if (bp || m == 0) eb = {pv[pp+3], pv[pp+2], pv[pp+1], pv[pp]};
            else eb = {sh[pb+3], sh[pb+2], sh[pb+1], sh[pb]};
        end
        for (int l = 0; l < 4; l++) begin
            if (ae && !ar && aw[l] && pa >= 0) sh[pa+l] = ad[8*l +: 8];
            if (be && !br && bw[l]) begin
                if (bp || m == 0) pv[pp+l] = bd[8*l +: 8];
                else sh[pb+l] = bd[8*l +: 8];
            end
        end
        m_ctrl = nctrl;
        @(negedge clk);
        check(a_rdata, ea, {ta, " port A"});
        check(b_rdata, eb, {tb, " port B"});
    endtask

    task automatic idle(input string tg);
        cyc(0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 4'h0, 0, tg);
    endtask

    task automatic set_mode(input int m);
        cyc(1, 1, 0, 4'h1, 32'(m), 0, 0, 0, 0, 4'h0, 0, "R8");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < S; i++) sh[i] = 8'h00;
        for (int i = 0; i < P; i++) pv[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(a_rdata, 32'h0, "R1 port A after reset");
        check(b_rdata, 32'h0, "R1 port B after reset");
        cyc(1, 1, 0, 4'h0, 0, 1, 1, 0, 0, 4'h0, 0, "R1");

        // Clear every word (R2 full array from A, R6 private from B)
        for (int i = 0; i < P/4; i++) begin
            cyc(i < S/4, 0, i*4, 4'hF, 0, 1, 0, 1, i*4, 4'hF, 0, "");
        end

        // Per-mode directed traffic with mirrors
        for (int m = 0; m < 4; m++) begin
            // R8: same-cycle access still uses the old mapping
            cyc(1, 1, 0, 4'h1, 32'(m), 1, 0, 0, 8, 4'h0, 0, "R8");
            cyc(0, 0, 0, 4'h0, 0, 1, 0, 0, 8, 4'h0, 0, "R8");
            cyc(1, 0, 12, 4'hF, 32'hA000_0000 + 32'(m), 1, 0, 0, 16, 4'hF, 32'hB000_0000 + 32'(m), "");
            cyc(1, 0, 12 + S*5, 4'h0, 0, 1, 0, 0, 16 + H*3, 4'h0, 0, "");
            cyc(1, 0, 12 + H, 4'h0, 0, 1, 0, 0, 16 + P*7, 4'h0, 0, "");
            cyc(1, 0, H + 4, 4'hF, 32'hC0DE_0000 + 32'(m), 1, 0, 1, 20, 4'hF, 32'h5A5A_0000 + 32'(m), "");
            cyc(1, 0, 4, 4'h0, 0, 1, 0, 1, 20 + P, 4'h0, 0, "");
            cyc(1, 0, H + 4, 4'h0, 0, 1, 0, 0, H + 4, 4'h0, 0, "");
            idle("R10");
        end

        // R4: swap of halves between modes 1 and 2 keeps contents
        set_mode(1);
        cyc(1, 0, 0, 4'hF, 32'h1111_1111, 1, 0, 0, 0, 4'hF, 32'h2222_2222, "R4");
        set_mode(2);
        cyc(1, 0, 0, 4'h0, 0, 1, 0, 0, 0, 4'h0, 0, "R4");

        // R9: lane-selective writes
        cyc(1, 0, 0, 4'b0010, 32'hFFFF_FFFF, 1, 0, 1, 0, 4'b1100, 32'hEEEE_EEEE, "R9");
        cyc(1, 0, 2, 4'h0, 0, 1, 0, 1, 3, 4'h0, 0, "R9");

        // R7: port B register write ignored; upper bytes read zero
        cyc(0, 0, 0, 4'h0, 0, 1, 1, 0, 0, 4'hF, 32'hFFFF_FF03, "R7");
        cyc(1, 1, 0, 4'h0, 0, 1, 1, 0, 0, 4'h0, 0, "R7");
        cyc(1, 1, 0, 4'hE, 32'h0000_0003, 0, 0, 0, 0, 4'h0, 0, "R7");
        cyc(1, 1, 0, 4'h1, 32'hFFFF_FFFE, 1, 1, 0, 0, 4'h0, 0, "R7");
        cyc(1, 1, 0, 4'h0, 0, 0, 0, 0, 0, 4'h0, 0, "R7");

        // Mixed random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic ae, ar, be, br, bp;
            logic [3:0] aw, bw;
            ae = ($urandom % 4) != 0;
            ar = ($urandom % 24) == 0;
            aw = ($urandom % 2) ? 4'h0 : 4'($urandom);
            be = ($urandom % 4) != 0;
            br = ($urandom % 24) == 0;
            bp = ($urandom % 5) == 0;
            bw = ($urandom % 2) ? 4'h0 : 4'($urandom);
            cyc(ae, ar, int'($urandom & 16'hFFFF), aw, $urandom,
                be, br, bp, int'($urandom & 16'hFFFF), bw, $urandom, "");
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule